// File: doc/BRIEF.md
# LDPC Soft-Value Column Assembler

This block sits in front of a quasi-cyclic LDPC decoding core. It takes the soft values (LLRs) of one code block from a 64-lane streaming bus. It regroups them into circulant columns of Z values and hands each finished column to the core in a single cycle, together with its column number.

A 12-bit mode word is sampled with the first beat of a block and selects the base graph, the code rate and the lifting size. From these the block derives Z, the column count nb and the number of input beats it expects. It then emits two all-zero columns that stand in for the punctured columns, and after them one column for every Z received values.

Each column starts on a fresh bus beat, so the last beat of a column carries unused upper lanes, which are dropped. Mode words that select an unsupported combination, and blocks whose end marker comes on the wrong beat, raise one-cycle error pulses.

Top module: `llr_col_assembler`

## Requirements
- R1: The Z index in mode bits 5:0 selects Z in ascending order from the set 2..16 (step 1), 18..32 (step 2), 36..64 (step 4), 72..128 (step 8), 144..256 (step 16) and 288..384 (step 32), so that index 43 gives 208 and index 50 gives 384. In every emitted column, lanes at or above Z read zero.
- R2: Mode bit 11 selects the graph (0 = first, 1 = second) and bits 10:8 select the rate index. The column count nb is 68, 57, 46, 35, 32, 29, 27 for rate indices 1..7 of the first graph, and 52, 32, 27, 22, 17 for rate indices 0..4 of the second graph. A well-formed block yields exactly nb columns, numbered 0..nb-1, and takes exactly (nb-2)*ceil(Z/64) accepted beats.
- R3: Column LLR k comes from beat k/64 of that column, lane k%64, where lane l of a beat is bits [l*W +: W]. The lanes at or above Z mod 64 on the final beat of a column are discarded.
- R4: On a supported start of block, columns 0 and 1 are emitted with all-zero data in the two cycles after the sop beat is first presented, before any beat of the block is accepted. Received data therefore begins in column 2.
- R5: in_ready_o is low while idle and high while a block is being received or drained.
- R6: col_valid_o is high for one cycle, in the cycle after the edge that accepts the final beat of a column.
- R7: A mode word with the first graph and rate index 0, the second graph and rate index 5..7, or a Z index above 50 gives a one-cycle mode_err_o pulse. No columns are emitted, and beats are drained up to and including eop.
- R8: An eop before the final beat gives a one-cycle frame_err_o pulse and abandons the block without emitting the incomplete column. A final beat without eop emits its column, pulses frame_err_o and drains beats up to eop.
- R9: col_mode_o carries the full 12-bit mode word sampled with sop, all bits unchanged, for every column of the block.
- R10: After reset, in_ready_o, col_valid_o, mode_err_o and frame_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_sop_i | input | 1 | First beat of a block |
| in_eop_i | input | 1 | Last beat of a block |
| in_data_i | input | LANES*LLR_W | 64 LLR lanes, lane 0 lowest |
| in_mode_i | input | 12 | Mode word, sampled with sop |
| col_valid_o | output | 1 | Assembled column valid |
| col_idx_o | output | 7 | Column number |
| col_data_o | output | ZMAX*LLR_W | Column LLRs, LLR 0 lowest |
| col_mode_o | output | 12 | Mode word of the current block |
| mode_err_o | output | 1 | Unsupported mode pulse |
| frame_err_o | output | 1 | Misplaced or missing eop pulse |

## Verification
A wrong beat-in-column or column counter shows at the ports within one column time. Either col_valid_o pulses on the wrong cycle or col_idx_o skips or repeats, and the cycle-exact model reports this on the next clock. A stale or misrouted lane in the column buffer shows as a data mismatch on that column's valid cycle. A wrong nb or Z decode shows at the latest at the end of the block, as a missing or extra column or a spurious frame_err_o.

// File: rtl/llr_asm_pkg.sv
package llr_asm_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PAD1, S_RECV, S_DROP} state_e;

  // Lifting size from the 6-bit size index (indices above 50 are flagged elsewhere)
  function automatic int z_of_idx(input logic [5:0] idx);
    int i;
    i = int'(idx);
    if (i < 15)      return i + 2;
    else if (i < 23) return 18 + 2 * (i - 15);
    else if (i < 31) return 36 + 4 * (i - 23);
    else if (i < 39) return 72 + 8 * (i - 31);
    else if (i < 47) return 144 + 16 * (i - 39);
    else             return 288 + 32 * (i - 47);
  endfunction

  // Column count; 0 marks an unsupported graph/rate pair
  function automatic int nb_of(input logic bg, input logic [2:0] rate);
    if (!bg) begin
      case (rate)
        3'd1: return 68;
        3'd2: return 57;
        3'd3: return 46;
        3'd4: return 35;
        3'd5: return 32;
        3'd6: return 29;
        3'd7: return 27;
        default: return 0;
      endcase
    end else begin
      case (rate)
        3'd0: return 52;
        3'd1: return 32;
        3'd2: return 27;
        3'd3: return 22;
        3'd4: return 17;
        default: return 0;
      endcase
    end
  endfunction

endpackage

// File: rtl/llr_mode_decode.sv
module llr_mode_decode
  import llr_asm_pkg::*;
#(
  parameter int LANES = 64,
  parameter int ZMAX  = 384,
  parameter int ZW    = 9,
  parameter int NBW   = 7,
  parameter int BW    = 3
) (
  input  logic [11:0]    mode_i,
  output logic [ZW-1:0]  z_o,
  output logic [NBW-1:0] nb_o,
  output logic [BW-1:0]  bpc_o,
  output logic           ok_o
);
  int z_int;
  int nb_int;

  always_comb begin
    z_int  = z_of_idx(mode_i[5:0]);
    nb_int = nb_of(mode_i[11], mode_i[10:8]);
    z_o    = ZW'(z_int);
    nb_o   = NBW'(nb_int);
    bpc_o  = BW'((z_int + LANES - 1) / LANES);
    ok_o   = (mode_i[5:0] <= 6'd50) && (nb_int != 0) && (z_int <= ZMAX);
  end

  always_comb begin
    if (ok_o) begin
      p_size_range_r1: assert (z_o >= ZW'(2) && bpc_o != '0);
    end
  end
endmodule

// File: rtl/llr_col_buffer.sv
module llr_col_buffer #(
  parameter int LANES = 64,
  parameter int LLR_W = 6,
  parameter int ZMAX  = 384,
  parameter int ZW    = 9,
  parameter int BW    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [BW-1:0]          beat_i,
  input  logic [LANES*LLR_W-1:0] data_i,
  input  logic [ZW-1:0]          z_i,
  input  logic                   emit_i,
  input  logic                   zero_i,
  output logic [ZMAX*LLR_W-1:0]  col_o
);
  localparam int BPC_MAX = (ZMAX + LANES - 1) / LANES;

  logic [LLR_W-1:0] buf_q [ZMAX];
  logic [LLR_W-1:0] out_q [ZMAX];

  for (genvar j = 0; j < ZMAX; j++) begin : g_lane
    localparam int SEG = j / LANES;
    localparam int SUB = j % LANES;
    logic hit;
    assign hit = (beat_i == BW'(SEG));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[j] <= '0;
        out_q[j] <= '0;
      end else begin
        if (wr_i && hit) buf_q[j] <= data_i[SUB*LLR_W +: LLR_W];
        if (zero_i) begin
          out_q[j] <= '0;
        end else if (emit_i) begin
          // the final beat bypasses the buffer; lanes past Z are blanked
          if (ZW'(j) < z_i) out_q[j] <= hit ? data_i[SUB*LLR_W +: LLR_W] : buf_q[j];
          else              out_q[j] <= '0;
        end
      end
    end

    assign col_o[j*LLR_W +: LLR_W] = out_q[j];
  end

  p_beat_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (int'(beat_i) < BPC_MAX));
endmodule

// File: rtl/llr_col_assembler.sv
module llr_col_assembler
  import llr_asm_pkg::*;
#(
  parameter int LANES = 64,
  parameter int LLR_W = 6,
  parameter int ZMAX  = 384
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic                   in_sop_i,
  input  logic                   in_eop_i,
  input  logic [LANES*LLR_W-1:0] in_data_i,
  input  logic [11:0]            in_mode_i,
  output logic                   col_valid_o,
  output logic [6:0]             col_idx_o,
  output logic [ZMAX*LLR_W-1:0]  col_data_o,
  output logic [11:0]            col_mode_o,
  output logic                   mode_err_o,
  output logic                   frame_err_o
);
  localparam int NB_MAX  = 68;
  localparam int NBW     = $clog2(NB_MAX + 1);
  localparam int ZW      = $clog2(ZMAX + 1);
  localparam int BPC_MAX = (ZMAX + LANES - 1) / LANES;
  localparam int BW      = $clog2(BPC_MAX + 1);

  state_e         state_q;
  logic [11:0]    mode_q;
  logic [ZW-1:0]  z_q, dz;
  logic [NBW-1:0] nb_q, dnb, col_q, col_idx_q;
  logic [BW-1:0]  bpc_q, dbpc, beat_q;
  logic           dok;
  logic           col_valid_q, merr_q, ferr_q;
  logic           accept, wr_en, last_beat_col, last_col, final_beat, bad_eop, emit, pad_zero;

  llr_mode_decode #(.LANES(LANES), .ZMAX(ZMAX), .ZW(ZW), .NBW(NBW), .BW(BW)) u_dec (
    .mode_i (in_mode_i),
    .z_o    (dz),
    .nb_o   (dnb),
    .bpc_o  (dbpc),
    .ok_o   (dok)
  );

  assign in_ready_o    = (state_q == S_RECV) || (state_q == S_DROP);
  assign accept        = in_valid_i && in_ready_o;
  assign wr_en         = accept && (state_q == S_RECV);
  assign last_beat_col = (beat_q == BW'(bpc_q - 1'b1));
  assign last_col      = (col_q == NBW'(nb_q - 1'b1));
  assign final_beat    = last_beat_col && last_col;
  assign bad_eop       = wr_en && in_eop_i && !final_beat;
  assign emit          = wr_en && !bad_eop && last_beat_col;
  assign pad_zero      = ((state_q == S_IDLE) && in_valid_i && in_sop_i && dok) || (state_q == S_PAD1);

  llr_col_buffer #(.LANES(LANES), .LLR_W(LLR_W), .ZMAX(ZMAX), .ZW(ZW), .BW(BW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en),
    .beat_i (beat_q),
    .data_i (in_data_i),
    .z_i    (z_q),
    .emit_i (emit),
    .zero_i (pad_zero),
    .col_o  (col_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      mode_q      <= '0;
      z_q         <= '0;
      nb_q        <= '0;
      bpc_q       <= '0;
      beat_q      <= '0;
      col_q       <= '0;
      col_idx_q   <= '0;
      col_valid_q <= 1'b0;
      merr_q      <= 1'b0;
      ferr_q      <= 1'b0;
    end else begin
      col_valid_q <= 1'b0;
      merr_q      <= 1'b0;
      ferr_q      <= 1'b0;
      unique case (state_q)
        S_IDLE: if (in_valid_i && in_sop_i) begin
          mode_q <= in_mode_i;
          z_q    <= dz;
          nb_q   <= dnb;
          bpc_q  <= dbpc;
          if (dok) begin
            col_valid_q <= 1'b1;
            col_idx_q   <= '0;
            state_q     <= S_PAD1;
          end else begin
            merr_q  <= 1'b1;
            state_q <= S_DROP;
          end
        end
        S_PAD1: begin
          col_valid_q <= 1'b1;
          col_idx_q   <= NBW'(1);
          beat_q      <= '0;
          col_q       <= NBW'(2);
          state_q     <= S_RECV;
        end
        S_RECV: if (wr_en) begin
          if (bad_eop) begin
            ferr_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            if (last_beat_col) begin
              col_valid_q <= 1'b1;
              col_idx_q   <= col_q;
              col_q       <= col_q + 1'b1;
              beat_q      <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
            if (final_beat) begin
              state_q <= in_eop_i ? S_IDLE : S_DROP;
              ferr_q  <= !in_eop_i;
            end
          end
        end
        S_DROP: if (accept && in_eop_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign col_valid_o = col_valid_q;
  assign col_idx_o   = col_idx_q;
  assign col_mode_o  = mode_q;
  assign mode_err_o  = merr_q;
  assign frame_err_o = ferr_q;

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_idx_o < 7'd2) |-> (col_data_o == '0));
  p_pad_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_idx_o == 7'd0) |=> (col_valid_o && col_idx_o == 7'd1));
  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_valid_o |-> (col_idx_o < nb_q));
  p_ready_after_pad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_idx_o == 7'd1) |-> in_ready_o);
  p_merr_no_col_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !col_valid_o);
  p_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_err_o && frame_err_o));
endmodule

// File: tb/llr_col_assembler_tb_top.sv
module llr_col_assembler_tb_top;
  localparam int LANES = 64;
  localparam int LLR_W = 6;
  localparam int ZMAX  = 384;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic                   in_ready;
  logic [LANES*LLR_W-1:0] in_data = '0;
  logic [11:0]            in_mode = '0;
  logic                   col_valid, mode_err, frame_err;
  logic [6:0]             col_idx;
  logic [ZMAX*LLR_W-1:0]  col_data;
  logic [11:0]            col_mode;

  always #5 clk = ~clk;

  llr_col_assembler #(.LANES(LANES), .LLR_W(LLR_W), .ZMAX(ZMAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_data_i(in_data), .in_mode_i(in_mode),
    .col_valid_o(col_valid), .col_idx_o(col_idx), .col_data_o(col_data),
    .col_mode_o(col_mode), .mode_err_o(mode_err), .frame_err_o(frame_err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int cols_seen = 0, merr_seen = 0, ferr_seen = 0;

  task automatic chk(input bit ok, input string what, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  function automatic int ref_z(input int idx);
    int z = 2;
    for (int i = 0; i < idx; i++)
      z += (z < 16) ? 1 : (z < 32) ? 2 : (z < 64) ? 4 : (z < 128) ? 8 : (z < 256) ? 16 : 32;
    return z;
  endfunction

  function automatic int ref_nb(input logic [11:0] m);
    int g1 [8] = '{0, 68, 57, 46, 35, 32, 29, 27};
    int g2 [8] = '{52, 32, 27, 22, 17, 0, 0, 0};
    return m[11] ? g2[m[10:8]] : g1[m[10:8]];
  endfunction

  // behavioural reference, advanced once per clock
  int                    mstate = 0; // 0 idle, 1 second pad, 2 receiving, 3 draining
  logic [11:0]           m_mode;
  int                    m_z, m_nb, m_total, m_beats, m_next_col;
  logic [LLR_W-1:0]      m_q[$];
  logic                  e_valid = 0, e_merr = 0, e_ferr = 0;
  int                    e_idx = 0;
  logic [ZMAX*LLR_W-1:0] e_data = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mstate = 0; e_valid = 0; e_merr = 0; e_ferr = 0;
    end else begin
      logic e_rdy;
      e_rdy = (mstate == 2) || (mstate == 3);
      chk(in_ready === e_rdy, "R5 in_ready", $sformatf("%b", in_ready), $sformatf("%b", e_rdy));
      chk(col_valid === e_valid, "R6 col_valid", $sformatf("%b", col_valid), $sformatf("%b", e_valid));
      chk(mode_err === e_merr, "R7 mode_err", $sformatf("%b", mode_err), $sformatf("%b", e_merr));
      chk(frame_err === e_ferr, "R8 frame_err", $sformatf("%b", frame_err), $sformatf("%b", e_ferr));
      if (e_valid && col_valid) begin
        chk(int'(col_idx) == e_idx, "R2 R4 col_idx", $sformatf("%0d", col_idx), $sformatf("%0d", e_idx));
        chk(col_data === e_data, (e_idx < 2) ? "R4 pad data" : "R1 R3 col_data",
            $sformatf("%h", col_data), $sformatf("%h", e_data));
        chk(col_mode === m_mode, "R9 col_mode", $sformatf("%h", col_mode), $sformatf("%h", m_mode));
      end
      if (col_valid) cols_seen++;
      if (mode_err) merr_seen++;
      if (frame_err) ferr_seen++;

      e_valid = 0; e_merr = 0; e_ferr = 0;
      case (mstate)
        0: if (in_valid && in_sop) begin
          m_mode = in_mode;
          m_nb = ref_nb(in_mode);
          m_z = ref_z(int'(in_mode[5:0]));
          if (in_mode[5:0] <= 6'd50 && m_nb != 0) begin
            e_valid = 1; e_idx = 0; e_data = '0; mstate = 1;
          end else begin
            e_merr = 1; mstate = 3;
          end
        end
        1: begin
          e_valid = 1; e_idx = 1; e_data = '0; mstate = 2;
          m_total = (m_nb - 2) * ((m_z + 63) / 64);
          m_beats = 0; m_next_col = 2; m_q.delete();
        end
        2: if (in_valid) begin
          bit fin;
          m_beats++;
          fin = (m_beats == m_total);
          if (in_eop && !fin) begin
            e_ferr = 1; mstate = 0;
          end else begin
            for (int l = 0; l < LANES && m_q.size() < m_z; l++) m_q.push_back(in_data[l*LLR_W +: LLR_W]);
            if (m_q.size() == m_z) begin
              e_valid = 1; e_idx = m_next_col++; e_data = '0;
              foreach (m_q[k]) e_data[k*LLR_W +: LLR_W] = m_q[k];
              m_q.delete();
            end
            if (fin) begin
              mstate = in_eop ? 0 : 3; e_ferr = !in_eop;
            end
          end
        end
        3: if (in_valid && in_eop) mstate = 0;
        default: mstate = 0;
      endcase
    end
  end

  task automatic send_block(input logic [11:0] m, input int nbeats, input int eop_at, input bit gaps,
                            input int exp_cols, input int exp_merr, input int exp_ferr, input string tag);
    cols_seen = 0; merr_seen = 0; ferr_seen = 0;
    for (int b = 0; b < nbeats; b++) begin
      bit rdy;
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 0; @(posedge clk); #1;
      end
      in_valid = 1; in_sop = (b == 0); in_eop = (b == eop_at); in_mode = m;
      for (int l = 0; l < LANES; l++) in_data[l*LLR_W +: LLR_W] = LLR_W'($urandom);
      do begin
        @(negedge clk); rdy = in_ready;
        @(posedge clk); #1;
      end while (!rdy);
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(cols_seen == exp_cols, {tag, " R2 column count"}, $sformatf("%0d", cols_seen), $sformatf("%0d", exp_cols));
    chk(merr_seen == exp_merr, {tag, " R7 mode_err count"}, $sformatf("%0d", merr_seen), $sformatf("%0d", exp_merr));
    chk(ferr_seen == exp_ferr, {tag, " R8 frame_err count"}, $sformatf("%0d", ferr_seen), $sformatf("%0d", exp_ferr));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(in_ready === 0 && col_valid === 0 && mode_err === 0 && frame_err === 0, "R10 reset outputs",
        $sformatf("%b%b%b%b", in_ready, col_valid, mode_err, frame_err), "0000");
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    // second graph, rate 1/2, Z=208 (index 43), 80 beats; bit 7 set for echo
    send_block({1'b1, 3'd3, 1'b1, 1'b0, 6'd43}, 80, 79, 0, 22, 0, 0, "Z208");
    // first graph, top rate, Z=384, 150 beats; bit 6 set
    send_block({1'b0, 3'd7, 1'b0, 1'b1, 6'd50}, 150, 149, 0, 27, 0, 0, "Z384");
    // smallest Z, gaps in valid
    send_block({1'b1, 3'd4, 2'b00, 6'd0}, 15, 14, 1, 17, 0, 0, "Z2");
    // Z a multiple of 64
    send_block({1'b0, 3'd5, 2'b11, 6'd30}, 30, 29, 0, 32, 0, 0, "Z64");
    // unsupported modes
    send_block({1'b0, 3'd0, 2'b00, 6'd10}, 3, 2, 0, 0, 1, 0, "R7 g1r0");
    send_block({1'b1, 3'd6, 2'b00, 6'd10}, 1, 0, 0, 0, 1, 0, "R7 g2r6");
    send_block({1'b0, 3'd1, 2'b00, 6'd51}, 4, 3, 1, 0, 1, 0, "R7 idx51");
    // early eop: 5 complete columns then abandoned
    send_block({1'b1, 3'd4, 2'b00, 6'd0}, 6, 5, 0, 7, 0, 1, "R8 early");
    // missing eop on final beat, drained after
    send_block({1'b1, 3'd4, 2'b00, 6'd0}, 17, 16, 0, 17, 0, 1, "R8 late");
    // recovery with gaps
    send_block({1'b1, 3'd3, 2'b10, 6'd43}, 80, 79, 1, 22, 0, 0, "Z208 gaps");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule